// File: doc/BRIEF.md
# Serial Receiver with Sleep and Wakeup

This block receives asynchronous serial characters on one input line and delivers them as parallel bytes. The line is resynchronised and then sampled on a 16x bit-rate tick supplied from outside. Each bit, the start bit included, is decided by a two-of-three vote over the ticks around the middle of the bit. A finished character moves from the shift register into a holding register that software reads. The next character can therefore arrive while the previous one is still waiting. Status outputs report a waiting character, an idle line, a lost character, noisy sampling and a bad stop bit.

In a multi-drop system, software on a node that sees a message addressed elsewhere sets a sleep bit. While the node sleeps, no status flag can become set and no character is loaded. Hardware clears the sleep bit on one of two events, chosen by a mode input. In idle-line mode the event is a full frame time of idle line. In address-mark mode it is a character whose most significant bit is 1, and that character is delivered as a normal reception.

Top module: `uart_wake_rx`

## Requirements
- R1: Frames are one low start bit, 8 data bits sent LSB first, and one stop bit. A completed frame loads `rx_data` and sets `rdrf`. A one-cycle `rd_data` pulse clears `rdrf`, `overrun`, `noise`, `frame_err` and `idle`, and leaves `rx_data` unchanged.
- R2: Each bit takes the majority of the line samples at ticks 7, 8 and 9 of its 16-tick cell, counted from the tick that first saw the start edge as tick 0. A single-tick glitch on one of those samples does not change the received value, but it sets `noise` for that character.
- R3: A stop bit that votes low sets `frame_err`, and the character is still loaded.
- R4: If a frame completes while `rdrf` is 1 and no read arrives in that cycle, `overrun` is set, the new character is discarded and `rx_data` keeps the old character.
- R5: If a read arrives in the same cycle as a frame completion, the new character is loaded, `rdrf` stays set and `overrun` is not set.
- R6: A low pulse whose start-bit vote comes out high is rejected as a false start. It produces no character and no flag.
- R7: `idle` is set after 160 consecutive ticks (ten bit times) of high line while no frame is in progress. This happens only if a character has been accepted since the last idle detection, and at most once per idle period. No character since reset means no `idle`.
- R8: A one-cycle `rwu_set` pulse sets `rwu`. While `rwu` is 1, `rdrf`, `idle`, `overrun`, `noise` and `frame_err` cannot become set and `rx_data` is not loaded.
- R9: With `wake_mode` = 0 (idle-line), idle detection clears `rwu` without setting `idle`. The next frame is then received normally.
- R10: With `wake_mode` = 1 (address-mark), a character whose bit 7 is 1 clears `rwu` and is loaded and flagged as a normal character. Characters whose bit 7 is 0, and idle periods, leave the receiver asleep.
- R11: A one-cycle `rwu_clr` pulse clears `rwu`. If `rwu_set` and `rwu_clr` arrive in the same cycle, `rwu_set` wins.
- R12: After reset, all flags, `rwu` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| wake_mode | input | 1 | 0 = idle-line wakeup, 1 = address-mark wakeup |
| rwu_set | input | 1 | Pulse: put the receiver to sleep |
| rwu_clr | input | 1 | Pulse: software wake |
| rd_data | input | 1 | Pulse: read of the data register, clears flags |
| rx_data | output | 8 | Last accepted character |
| rdrf | output | 1 | Character waiting to be read |
| idle | output | 1 | Idle line detected after traffic |
| overrun | output | 1 | A character was lost |
| noise | output | 1 | Sample disagreement in the loaded character |
| frame_err | output | 1 | Stop bit of the loaded character was low |
| rwu | output | 1 | Receiver asleep |

## Verification
Two events can land in the same clock cycle: a software read, and the completion of a new character while the previous one is unread. The bench sends a second character without reading the first. It raises `rd_data` for exactly the cycle after the tick that decides the stop bit, which is the cycle in which the status logic sees the completion. The result is judged at the ports. `rx_data` must hold the new character and `overrun` must stay 0. A design that lets the overrun path win would still show the old character.

// File: rtl/uart_wake_rx_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the serial receiver with wakeup.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package uart_wake_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // Two-of-three vote.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // High when the three samples are not all equal.
    function automatic logic split3(input logic a, input logic b, input logic c);
        return !((a == b) && (b == c));
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
`timescale 1ns/1ps
// Resynchronises the asynchronous serial line into the clock domain.
// Assumes the line idles high, so every stage resets to 1.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    // Shift the line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '1;
        else        stage_q <= {stage_q[STAGES-2:0], din};
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
`timescale 1ns/1ps
// Start detection, majority-vote bit sampling and framing.
// Assumes tick is a one-cycle enable at OSR times the bit rate. The
// tick that first sees a low line is tick 0 of the start cell. Each bit
// is decided at tick MID+1 from samples MID-1, MID and MID+1. The
// engine returns to idle right after the stop decision, so a start
// edge that follows at once is caught.
module rx_frame_engine
    import uart_wake_rx_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [DATA_BITS-1:0] word_o,
    output logic                 noise_o,
    output logic                 ferr_o
);
    localparam int CW    = $clog2(OSR);
    localparam int BW    = $clog2(DATA_BITS);
    localparam int MID   = OSR / 2;
    localparam logic [CW-1:0] SMP_A = CW'(MID - 1);
    localparam logic [CW-1:0] SMP_B = CW'(MID);
    localparam logic [CW-1:0] SMP_C = CW'(MID + 1);
    localparam logic [CW-1:0] LAST  = CW'(OSR - 1);
    localparam logic [BW-1:0] TOPB  = BW'(DATA_BITS - 1);

    rx_state_e            state_q;
    logic [CW-1:0]        cnt_q;
    logic [BW-1:0]        bit_q;
    logic                 smp_a_q, smp_b_q;
    logic [DATA_BITS-1:0] shreg_q;
    logic                 noisy_q;
    logic                 vote, split;

    // Vote on the two stored samples and the live third one.
    always_comb begin
        vote  = maj3(smp_a_q, smp_b_q, line);
        split = split3(smp_a_q, smp_b_q, line);
    end

    // Frame sequencer: count ticks, sample, decide bits, emit a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            smp_a_q <= 1'b1;
            smp_b_q <= 1'b1;
            shreg_q <= '0;
            noisy_q <= 1'b0;
            done_o  <= 1'b0;
            word_o  <= '0;
            noise_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick) begin
                if (state_q == RX_IDLE) begin
                    if (!line) begin
                        state_q <= RX_START;
                        cnt_q   <= CW'(1);
                    end
                end else begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                    if (cnt_q == SMP_A) smp_a_q <= line;
                    if (cnt_q == SMP_B) smp_b_q <= line;
                    if (cnt_q == SMP_C) begin
                        case (state_q)
                            RX_START: begin
                                if (vote) begin
                                    state_q <= RX_IDLE;
                                end else begin
                                    state_q <= RX_DATA;
                                    bit_q   <= '0;
                                    noisy_q <= split;
                                end
                            end
                            RX_DATA: begin
                                shreg_q <= {vote, shreg_q[DATA_BITS-1:1]};
                                noisy_q <= noisy_q | split;
                                if (bit_q == TOPB) state_q <= RX_STOP;
                                else               bit_q   <= bit_q + 1'b1;
                            end
                            default: begin
                                done_o  <= 1'b1;
                                word_o  <= shreg_q;
                                noise_o <= noisy_q | split;
                                ferr_o  <= !vote;
                                state_q <= RX_IDLE;
                            end
                        endcase
                    end
                end
            end
        end
    end

    assign busy_o = (state_q != RX_IDLE);

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/rx_idle_detect.sv
`timescale 1ns/1ps
// Detects a full frame time of idle line between characters.
// Assumes busy is high while a frame is being sampled. Produces one
// pulse per idle period. The period ends when the line goes low.
module rx_idle_detect #(
    parameter int OSR       = 16,
    parameter int IDLE_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic busy,
    output logic idle_det_o
);
    localparam int LIMIT = OSR * IDLE_BITS;
    localparam int W     = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;
    logic         fired_q;

    // Count high ticks while no frame runs; fire once when the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            fired_q    <= 1'b0;
            idle_det_o <= 1'b0;
        end else begin
            idle_det_o <= 1'b0;
            if (busy || !line) begin
                cnt_q   <= '0;
                fired_q <= 1'b0;
            end else if (tick && !fired_q) begin
                if (cnt_q == TOP) begin
                    idle_det_o <= 1'b1;
                    fired_q    <= 1'b1;
                    cnt_q      <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R7
    idle_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_det_o |=> !idle_det_o);

endmodule

// File: rtl/rx_status_wake.sv
`timescale 1ns/1ps
// Receive data register, status flags and the sleep/wakeup bit.
// Assumes done_i is a one-cycle pulse carrying word_i, noise_i and
// ferr_i, and idle_det_i is a one-cycle pulse. A read in the same cycle
// as a completion lets the new word load. Setting sleep wins over any
// clear that arrives with it.
module rx_status_wake #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done_i,
    input  logic [DATA_BITS-1:0] word_i,
    input  logic                 noise_i,
    input  logic                 ferr_i,
    input  logic                 idle_det_i,
    input  logic                 wake_mode,
    input  logic                 rwu_set,
    input  logic                 rwu_clr,
    input  logic                 rd_data,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rdrf,
    output logic                 idle,
    output logic                 overrun,
    output logic                 noise,
    output logic                 frame_err,
    output logic                 rwu
);
    logic rdrf_q, idle_q, ovr_q, noise_q, ferr_q, rwu_q, armed_q;
    logic [DATA_BITS-1:0] data_q;
    logic mark_wake, line_wake, accept, load, lost;

    // Decide what this cycle's completion and idle events may do.
    always_comb begin
        mark_wake = done_i && rwu_q && wake_mode && word_i[DATA_BITS-1];
        line_wake = idle_det_i && rwu_q && !wake_mode;
        accept    = done_i && (!rwu_q || mark_wake);
        load      = accept && (!rdrf_q || rd_data);
        lost      = accept && rdrf_q && !rd_data;
    end

    // Data register and the flags set by a completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            rdrf_q  <= 1'b0;
            ovr_q   <= 1'b0;
            noise_q <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            if (load) data_q <= word_i;
            if (load)         rdrf_q  <= 1'b1;
            else if (rd_data) rdrf_q  <= 1'b0;
            if (lost)         ovr_q   <= 1'b1;
            else if (rd_data) ovr_q   <= 1'b0;
            if (load && noise_i) noise_q <= 1'b1;
            else if (rd_data)    noise_q <= 1'b0;
            if (load && ferr_i)  ferr_q  <= 1'b1;
            else if (rd_data)    ferr_q  <= 1'b0;
        end
    end

    // Idle flag, gated by traffic since the last idle and by sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (idle_det_i && armed_q && !rwu_q) idle_q <= 1'b1;
            else if (rd_data)                    idle_q <= 1'b0;
            if (idle_det_i)  armed_q <= 1'b0;
            else if (accept) armed_q <= 1'b1;
        end
    end

    // Sleep bit: software sets, software or a wake event clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 rwu_q <= 1'b0;
        else if (rwu_set)                           rwu_q <= 1'b1;
        else if (rwu_clr || mark_wake || line_wake) rwu_q <= 1'b0;
    end

    assign rx_data   = data_q;
    assign rdrf      = rdrf_q;
    assign idle      = idle_q;
    assign overrun   = ovr_q;
    assign noise     = noise_q;
    assign frame_err = ferr_q;
    assign rwu       = rwu_q;

    // R8
    sleep_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rwu_q) && rwu_q && !$past(rwu_set) |->
            !$rose(rdrf_q) && !$rose(idle_q) && !$rose(ovr_q) &&
            !$rose(noise_q) && !$rose(ferr_q) && $stable(data_q));

    // R4
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $stable(data_q));

    // R9
    line_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rwu_q) && !$past(rwu_clr) && !$past(wake_mode) |-> $past(idle_det_i));

    // R10
    mark_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rwu_q) && !$past(rwu_clr) && $past(wake_mode) |->
            $past(done_i) && $past(word_i[DATA_BITS-1]));

endmodule

// File: rtl/uart_wake_rx.sv
`timescale 1ns/1ps
// Top of the serial receiver with sleep and wakeup.
// Assumes tick16 is a one-cycle enable at 16x the bit rate and rxd
// idles high. Chains synchroniser, frame engine, idle detector and the
// status/wakeup register block.
module uart_wake_rx #(
    parameter int OSR         = 16,
    parameter int DATA_BITS   = 8,
    parameter int IDLE_BITS   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 rxd,
    input  logic                 wake_mode,
    input  logic                 rwu_set,
    input  logic                 rwu_clr,
    input  logic                 rd_data,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rdrf,
    output logic                 idle,
    output logic                 overrun,
    output logic                 noise,
    output logic                 frame_err,
    output logic                 rwu
);
    logic                 line_s, busy, done, w_noise, w_ferr, idle_det;
    logic [DATA_BITS-1:0] word;

    rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
    );

    rx_frame_engine #(.OSR(OSR), .DATA_BITS(DATA_BITS)) frame_i (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
        .busy_o(busy), .done_o(done), .word_o(word),
        .noise_o(w_noise), .ferr_o(w_ferr)
    );

    rx_idle_detect #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) idle_i (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
        .busy(busy), .idle_det_o(idle_det)
    );

    rx_status_wake #(.DATA_BITS(DATA_BITS)) stat_i (
        .clk(clk), .rst_n(rst_n), .done_i(done), .word_i(word),
        .noise_i(w_noise), .ferr_i(w_ferr), .idle_det_i(idle_det),
        .wake_mode(wake_mode), .rwu_set(rwu_set), .rwu_clr(rwu_clr),
        .rd_data(rd_data), .rx_data(rx_data), .rdrf(rdrf), .idle(idle),
        .overrun(overrun), .noise(noise), .frame_err(frame_err), .rwu(rwu)
    );
endmodule

// File: tb/uart_wake_rx_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the serial receiver with wakeup.
module uart_wake_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       wake_mode = 1'b0;
    logic       rwu_set = 1'b0;
    logic       rwu_clr = 1'b0;
    logic       rd_data = 1'b0;
    logic [7:0] rx_data;
    logic       rdrf, idle, overrun, noise, frame_err, rwu;

    int checks = 0;
    int errors = 0;

    uart_wake_rx dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .wake_mode(wake_mode), .rwu_set(rwu_set), .rwu_clr(rwu_clr),
        .rd_data(rd_data), .rx_data(rx_data), .rdrf(rdrf), .idle(idle),
        .overrun(overrun), .noise(noise), .frame_err(frame_err), .rwu(rwu)
    );

    always #4 clk = ~clk;

    // Tick generator: one cycle in four.
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 tick16 = 1'b1;
            @(posedge clk);
            #1 tick16 = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        @(posedge clk iff tick16);
        #2;
    endtask

    task automatic gap(input int n);
        rxd = 1'b1;
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    // Send one frame. glitch_pos: cell to glitch at tick 8 (-1 none).
    // read_at_done: pulse rd_data in the cycle the status block sees completion.
    task automatic send_frame(input logic [7:0] b, input logic stop_v,
                              input int glitch_pos, input bit read_at_done);
        for (int p = 0; p < 10; p++) begin
            logic v;
            v = (p == 0) ? 1'b0 : (p == 9) ? stop_v : b[p-1];
            for (int t = 0; t < 16; t++) begin
                rxd = (p == glitch_pos && t == 8) ? ~v : v;
                wait_tick();
                if (read_at_done && p == 9 && t == 9) begin
                    rd_data = 1'b1;
                    @(posedge clk);
                    #1 rd_data = 1'b0;
                end
            end
        end
        rxd = 1'b1;
    endtask

    task automatic do_read();
        #1 rd_data = 1'b1;
        @(posedge clk);
        #1 rd_data = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_rwu(input bit s, input bit c);
        rwu_set = s;
        rwu_clr = c;
        @(posedge clk);
        #1 rwu_set = 1'b0;
        rwu_clr = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        check("R12 rx_data", rx_data, 0);
        check("R12 flags", {rdrf, idle, overrun, noise, frame_err}, 0);
        check("R12 rwu", rwu, 0);
        gap(180);
        check("R7 no idle without traffic", idle, 0);
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 1'b1, -1, 0);
        gap(4);
        check("R1 data A5", rx_data, 8'hA5);
        check("R1 rdrf set", rdrf, 1);
        check("R1 clean flags", {overrun, noise, frame_err}, 0);
        do_read();
        check("R1 read clears rdrf", rdrf, 0);
        check("R1 read keeps data", rx_data, 8'hA5);
        send_frame(8'h3C, 1'b1, -1, 0);
        send_frame(8'h00, 1'b1, -1, 0);
        gap(2);
        check("R4 overrun on unread", overrun, 1);
        do_read();
        send_frame(8'hFF, 1'b1, -1, 0);
        gap(2);
        check("R1 data FF", rx_data, 8'hFF);
        do_read();
    endtask

    task automatic t_glitch();
        send_frame(8'h5A, 1'b1, 3, 0);
        gap(2);
        check("R2 vote keeps value", rx_data, 8'h5A);
        check("R2 noise set", noise, 1);
        do_read();
        check("R1 read clears noise", noise, 0);
        send_frame(8'h00, 1'b1, 9, 0);
        gap(2);
        check("R2 stop glitch noise", noise, 1);
        check("R2 stop glitch no ferr", frame_err, 0);
        do_read();
    endtask

    task automatic t_ferr();
        send_frame(8'h81, 1'b0, -1, 0);
        gap(4);
        check("R3 ferr set", frame_err, 1);
        check("R3 data loaded", rx_data, 8'h81);
        gap(40);
        check("R6 tail of bad stop not a frame", {overrun, rx_data}, {1'b0, 8'h81});
        do_read();
        check("R1 read clears ferr", frame_err, 0);
    endtask

    task automatic t_false_start();
        rxd = 1'b0;
        for (int i = 0; i < 4; i++) wait_tick();
        gap(60);
        check("R6 false start no rdrf", rdrf, 0);
        check("R6 false start flags", {overrun, noise, frame_err}, 0);
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 1'b1, -1, 0);
        send_frame(8'h22, 1'b1, -1, 0);
        gap(2);
        check("R4 overrun set", overrun, 1);
        check("R4 old data kept", rx_data, 8'h11);
        do_read();
        check("R1 read clears overrun", overrun, 0);
    endtask

    task automatic t_coincide();
        send_frame(8'h33, 1'b1, -1, 0);
        send_frame(8'h44, 1'b1, -1, 1);
        gap(2);
        check("R5 new word loaded", rx_data, 8'h44);
        check("R5 no overrun", overrun, 0);
        check("R5 rdrf stays set", rdrf, 1);
        do_read();
    endtask

    task automatic t_idle_flag();
        send_frame(8'h77, 1'b1, -1, 0);
        do_read();
        gap(170);
        check("R7 idle after traffic", idle, 1);
        do_read();
        gap(200);
        check("R7 idle once per period", idle, 0);
    endtask

    task automatic t_sleep_idle();
        wake_mode = 1'b0;
        pulse_rwu(1, 0);
        check("R8 rwu set", rwu, 1);
        send_frame(8'h12, 1'b1, 4, 0);
        send_frame(8'h34, 1'b0, -1, 0);
        gap(4);
        check("R8 no flags asleep", {rdrf, overrun, noise, frame_err}, 0);
        check("R8 data not loaded", rx_data, 8'h77);
        check("R8 still asleep", rwu, 1);
        gap(170);
        check("R9 idle wakes", rwu, 0);
        check("R9 no idle flag at wake", idle, 0);
        send_frame(8'h56, 1'b1, -1, 0);
        gap(2);
        check("R9 next frame received", {rdrf, rx_data}, {1'b1, 8'h56});
        do_read();
    endtask

    task automatic t_sleep_addr();
        wake_mode = 1'b1;
        pulse_rwu(1, 0);
        send_frame(8'h05, 1'b1, -1, 0);
        gap(4);
        check("R10 msb0 ignored", {rwu, rdrf}, 2'b10);
        gap(170);
        check("R10 idle keeps sleep", rwu, 1);
        check("R8 idle flag held off", idle, 0);
        send_frame(8'h85, 1'b1, -1, 0);
        gap(2);
        check("R10 mark wakes", rwu, 0);
        check("R10 mark loaded", {rdrf, rx_data}, {1'b1, 8'h85});
        do_read();
        send_frame(8'h06, 1'b1, -1, 0);
        gap(2);
        check("R10 awake receives", {rdrf, rx_data}, {1'b1, 8'h06});
        do_read();
        wake_mode = 1'b0;
    endtask

    task automatic t_rwu_sw();
        pulse_rwu(1, 0);
        check("R11 set", rwu, 1);
        pulse_rwu(0, 1);
        check("R11 software clear", rwu, 0);
        pulse_rwu(1, 1);
        check("R11 set wins", rwu, 1);
        pulse_rwu(0, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_basic();
        t_glitch();
        t_ferr();
        t_false_start();
        t_overrun();
        t_coincide();
        t_idle_flag();
        t_sleep_idle();
        t_sleep_addr();
        t_rwu_sw();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule